// File: doc/BRIEF.md
# Dual-Queue Conversion Command Scheduler

This block decides which of two command queues owns a single shared converter at any moment. Each queue is a list of up to `DEPTH` command words. Every word carries a pause marker and an end-of-queue marker. The scheduler holds one word pointer per queue and presents the word to run through `conv_sel_o` and `conv_ptr_o`. Each `conv_done_i` strobe retires the current word and moves the owning queue's pointer on.

Queue 1 always wins. A queue 1 trigger that lands while queue 2 is running aborts queue 2's current word and parks queue 2 as suspended. Queue 2 picks up the same word again in the cycle queue 1 stops. A queue 2 trigger that arrives while queue 1 owns the converter is held as pending. It starts one cycle after queue 1 stops.

Per-queue flags record completion, pause and trigger overrun; software clears each by writing 1 to its bit. A 4-bit code summarises the joint state of both queues.

Top module: `dqs_sched`

## Requirements
- R1: After reset both queues are idle (state code 0), both pointers are 0, `flags_o` is 0, `status_o` is 4'b0000 and `conv_busy_o` is 0.
- R2: Queue 1 starts on `q1_ext_trig_i` or `q1_sw_trig_i` when it is not active. While a queue is active, `conv_busy_o` is 1. `conv_sel_o` is 0 for queue 1 and 1 for queue 2, and `conv_ptr_o` shows that queue's pointer. Each `conv_done_i` advances the pointer by one.
- R3: When a word with its end-of-queue bit set, or the word at index DEPTH-1, completes, three things happen: the pointer returns to 0, the queue's completion flag sets, and the queue goes idle if its continuous input is low.
- R4: When a non-final word with its pause bit set completes, three things happen: the queue goes paused (state code 2), its pause flag sets, and the pointer advances. The next trigger resumes from that pointer.
- R5: If the queue's continuous input is high when its final word completes, the completion flag sets and the queue restarts at word 0 without leaving the active state.
- R6: A trigger for a queue that is active, suspended or pending sets that queue's overrun flag and does not otherwise change it.
- R7: Queue 2 starts on `q2_ext_trig_i`, `q2_sw_trig_i` or `q2_timer_i`. It goes straight to active when queue 1 is neither active nor triggered in the same cycle.
- R8: A queue 1 trigger while queue 2 is active drives `abort_o` high in that cycle. Queue 2 goes suspended (state code 3) with its pointer held. A `conv_done_i` in that cycle is discarded.
- R9: A suspended queue 2 becomes active in the same cycle that queue 1 stops, and it re-executes the word at its held pointer.
- R10: A queue 2 trigger while queue 1 is active, or triggered in the same cycle, makes queue 2 pending (state code 4). It becomes active one cycle after queue 1 stops, so status 4'b0011 or 4'b0111 shows for exactly one cycle.
- R11: `flags_o` bits are [0] q1 complete, [1] q1 pause, [2] q1 overrun, [3] q2 complete, [4] q2 pause, [5] q2 overrun. Writing 1 to a bit of `flag_clr_i` clears that bit. A hardware set in the same cycle wins.
- R12: `status_o[3:2]` encodes queue 1 as 00 idle, 01 paused, 10 active. `status_o[1:0]` encodes queue 2 as 00 idle, 01 paused, 10 active or suspended, 11 pending.
- R13: `conv_done_i` while no queue is active changes no state, pointer or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q1_ext_trig_i | input | 1 | Queue 1 external trigger |
| q1_sw_trig_i | input | 1 | Queue 1 software single-scan request |
| q1_cont_i | input | 1 | Queue 1 continuous looping enable |
| q1_pause_i | input | DEPTH | Queue 1 per-word pause bits |
| q1_eoq_i | input | DEPTH | Queue 1 per-word end-of-queue bits |
| q2_ext_trig_i | input | 1 | Queue 2 external trigger |
| q2_sw_trig_i | input | 1 | Queue 2 software single-scan request |
| q2_timer_i | input | 1 | Queue 2 periodic timer expiry pulse |
| q2_cont_i | input | 1 | Queue 2 continuous looping enable |
| q2_pause_i | input | DEPTH | Queue 2 per-word pause bits |
| q2_eoq_i | input | DEPTH | Queue 2 per-word end-of-queue bits |
| conv_done_i | input | 1 | Current conversion finished |
| flag_clr_i | input | 6 | Write-1-to-clear strobes for flags |
| conv_busy_o | output | 1 | A queue owns the converter |
| conv_sel_o | output | 1 | Owning queue (0 = queue 1, 1 = queue 2) |
| conv_ptr_o | output | $clog2(DEPTH) | Word index to convert |
| abort_o | output | 1 | Conversion in progress is cancelled |
| q1_state_o | output | 3 | Queue 1 state (0 idle, 1 active, 2 paused) |
| q2_state_o | output | 3 | Queue 2 state (0 idle, 1 active, 2 paused, 3 suspended, 4 pending) |
| flags_o | output | 6 | Completion, pause and overrun flags |
| status_o | output | 4 | Combined two-queue status code |

## Verification
A wrong queue state shows on `status_o` and `conv_sel_o` one cycle after the edge that caused it. A lost suspension shows most clearly: queue 2 resumes at a different `conv_ptr_o` than the one it held when aborted. A bad pointer appears on `conv_ptr_o` at the next retired word. An end-of-queue or pause decoded at the wrong index moves the completion or pause flag by one or more `conv_done_i` strobes. A pending state that does not drain leaves the transient codes on `status_o` for more than one cycle, and that is visible at once.

// File: rtl/dqs_pkg.sv
package dqs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACTIVE = 3'd1,
    ST_PAUSED = 3'd2,
    ST_SUSP   = 3'd3,
    ST_PEND   = 3'd4
  } q_state_e;

  localparam int NQ    = 2;
  localparam int NFLAG = 3 * NQ;

  function automatic logic [3:0] enc_status(q_state_e s1, q_state_e s2);
    logic [1:0] a, b;
    case (s1)
      ST_ACTIVE: a = 2'b10;
      ST_PAUSED: a = 2'b01;
      default:   a = 2'b00;
    endcase
    case (s2)
      ST_ACTIVE, ST_SUSP: b = 2'b10;
      ST_PAUSED:          b = 2'b01;
      ST_PEND:            b = 2'b11;
      default:            b = 2'b00;
    endcase
    return {a, b};
  endfunction
endpackage

// File: rtl/dqs_word_sel.sv
module dqs_word_sel #(
  parameter int DEPTH = 8,
  parameter int PW    = 3
) (
  input  logic [PW-1:0]    ptr_i,
  input  logic [DEPTH-1:0] pause_i,
  input  logic [DEPTH-1:0] eoq_i,
  output logic             last_o,
  output logic             pause_o
);
  // last slot is an implicit end of queue
  assign last_o  = eoq_i[ptr_i] | (ptr_i == PW'(DEPTH - 1));
  assign pause_o = pause_i[ptr_i];
endmodule

// File: rtl/dqs_flags.sv
module dqs_flags #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/dqs_status_enc.sv
module dqs_status_enc
  import dqs_pkg::*;
(
  input  q_state_e    q1_st_i,
  input  q_state_e    q2_st_i,
  output logic [3:0]  status_o
);
  assign status_o = enc_status(q1_st_i, q2_st_i);
endmodule

// File: rtl/dqs_sched.sv
module dqs_sched
  import dqs_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             q1_ext_trig_i,
  input  logic             q1_sw_trig_i,
  input  logic             q1_cont_i,
  input  logic [DEPTH-1:0] q1_pause_i,
  input  logic [DEPTH-1:0] q1_eoq_i,
  input  logic             q2_ext_trig_i,
  input  logic             q2_sw_trig_i,
  input  logic             q2_timer_i,
  input  logic             q2_cont_i,
  input  logic [DEPTH-1:0] q2_pause_i,
  input  logic [DEPTH-1:0] q2_eoq_i,
  input  logic             conv_done_i,
  input  logic [5:0]       flag_clr_i,
  output logic             conv_busy_o,
  output logic             conv_sel_o,
  output logic [PW-1:0]    conv_ptr_o,
  output logic             abort_o,
  output logic [2:0]       q1_state_o,
  output logic [2:0]       q2_state_o,
  output logic [5:0]       flags_o,
  output logic [3:0]       status_o
);
  q_state_e                 st_q   [NQ];
  q_state_e                 st_d   [NQ];
  logic [PW-1:0]            ptr_q  [NQ];
  logic [PW-1:0]            ptr_d  [NQ];
  logic [NQ-1:0][DEPTH-1:0] pause_v, eoq_v;
  logic [NQ-1:0]            last, pz, done, cont;
  logic [NFLAG-1:0]         set_f;
  logic                     trig1, trig2, run1, run2, stop1;

  assign pause_v = {q2_pause_i, q1_pause_i};
  assign eoq_v   = {q2_eoq_i, q1_eoq_i};
  assign cont    = {q2_cont_i, q1_cont_i};

  for (genvar g = 0; g < NQ; g++) begin : g_sel
    dqs_word_sel #(.DEPTH(DEPTH), .PW(PW)) u_sel (
      .ptr_i   (ptr_q[g]),
      .pause_i (pause_v[g]),
      .eoq_i   (eoq_v[g]),
      .last_o  (last[g]),
      .pause_o (pz[g])
    );
  end

  assign trig1 = q1_ext_trig_i | q1_sw_trig_i;
  assign trig2 = q2_ext_trig_i | q2_sw_trig_i | q2_timer_i;
  assign run1  = (st_q[0] == ST_ACTIVE);
  assign run2  = (st_q[1] == ST_ACTIVE);
  // a preempting q1 trigger discards q2's done strobe
  assign done  = {run2 & conv_done_i & ~trig1, run1 & conv_done_i};
  assign stop1 = done[0] & (last[0] ? ~q1_cont_i : pz[0]);

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    set_f = '0;
    for (int g = 0; g < NQ; g++) begin
      if (done[g]) begin
        if (last[g]) begin
          ptr_d[g]     = '0;
          set_f[3*g]   = 1'b1;
          if (!cont[g]) st_d[g] = ST_IDLE;
        end else begin
          ptr_d[g] = ptr_q[g] + 1'b1;
          if (pz[g]) begin
            set_f[3*g+1] = 1'b1;
            st_d[g]      = ST_PAUSED;
          end
        end
      end
    end
    if (run1) set_f[2] = trig1;
    else if (trig1) st_d[0] = ST_ACTIVE;
    case (st_q[1])
      ST_ACTIVE: begin
        set_f[5] = trig2;
        if (trig1) st_d[1] = ST_SUSP;
      end
      ST_SUSP: begin
        set_f[5] = trig2;
        if (stop1) st_d[1] = ST_ACTIVE;
      end
      ST_PEND: begin
        set_f[5] = trig2;
        if (!run1 && !trig1) st_d[1] = ST_ACTIVE;
      end
      default: if (trig2) st_d[1] = (run1 || trig1) ? ST_PEND : ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NQ; g++) begin
        st_q[g]  <= ST_IDLE;
        ptr_q[g] <= '0;
      end
    end else begin
      for (int g = 0; g < NQ; g++) begin
        st_q[g]  <= st_d[g];
        ptr_q[g] <= ptr_d[g];
      end
    end
  end

  dqs_flags #(.W(NFLAG)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_f),
    .clr_i   (flag_clr_i),
    .flags_o (flags_o)
  );

  dqs_status_enc u_enc (
    .q1_st_i  (st_q[0]),
    .q2_st_i  (st_q[1]),
    .status_o (status_o)
  );

  assign conv_busy_o = run1 | run2;
  assign conv_sel_o  = ~run1 & run2;
  assign conv_ptr_o  = run1 ? ptr_q[0] : ptr_q[1];
  assign abort_o     = run2 & trig1;
  assign q1_state_o  = st_q[0];
  assign q2_state_o  = st_q[1];
endmodule

// File: rtl/dqs_sched_chk.sv
module dqs_sched_chk
  import dqs_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       q1_ext_trig_i,
  input logic       q1_sw_trig_i,
  input logic       conv_done_i,
  input logic       conv_busy_o,
  input logic       conv_sel_o,
  input logic       abort_o,
  input logic [2:0] q1_state_o,
  input logic [2:0] q2_state_o,
  input logic [5:0] flags_o,
  input logic [3:0] status_o
);
  logic transient;
  assign transient = (status_o == 4'b0011) || (status_o == 4'b0111);

  assert_single_owner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(q1_state_o == ST_ACTIVE && q2_state_o == ST_ACTIVE));

  assert_abort_suspends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (q2_state_o == ST_SUSP && q1_state_o == ST_ACTIVE));

  assert_susp_under_q1_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q2_state_o == ST_SUSP) |-> (q1_state_o == ST_ACTIVE));

  assert_pend_brief_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    transient |=> !transient);

  assert_overrun_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q1_state_o == ST_ACTIVE && (q1_ext_trig_i || q1_sw_trig_i)) |=> flags_o[2]);

  assert_sel_needs_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_sel_o |-> conv_busy_o);

  assert_done_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[0]) |-> ($past(q1_state_o) == ST_ACTIVE && $past(conv_done_i)));
endmodule

bind dqs_sched dqs_sched_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .q1_ext_trig_i (q1_ext_trig_i),
  .q1_sw_trig_i  (q1_sw_trig_i),
  .conv_done_i   (conv_done_i),
  .conv_busy_o   (conv_busy_o),
  .conv_sel_o    (conv_sel_o),
  .abort_o       (abort_o),
  .q1_state_o    (q1_state_o),
  .q2_state_o    (q2_state_o),
  .flags_o       (flags_o),
  .status_o      (status_o)
);

// File: tb/dqs_sched_tb_top.sv
module dqs_sched_tb_top;
  localparam int DEPTH = 8;
  localparam int PW    = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             q1_ext = 0, q1_sw = 0, q1_cont = 0;
  logic [DEPTH-1:0] q1_pause = '0, q1_eoq = '0;
  logic             q2_ext = 0, q2_sw = 0, q2_tmr = 0, q2_cont = 0;
  logic [DEPTH-1:0] q2_pause = '0, q2_eoq = '0;
  logic             done = 0;
  logic [5:0]       clr = '0;
  logic             busy, sel, abort;
  logic [PW-1:0]    ptr;
  logic [2:0]       s1, s2;
  logic [5:0]       flags;
  logic [3:0]       status;
  int               checks = 0;
  int               fails  = 0;

  always #10 clk = ~clk;

  dqs_sched #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .q1_ext_trig_i(q1_ext), .q1_sw_trig_i(q1_sw), .q1_cont_i(q1_cont),
    .q1_pause_i(q1_pause), .q1_eoq_i(q1_eoq),
    .q2_ext_trig_i(q2_ext), .q2_sw_trig_i(q2_sw), .q2_timer_i(q2_tmr),
    .q2_cont_i(q2_cont), .q2_pause_i(q2_pause), .q2_eoq_i(q2_eoq),
    .conv_done_i(done), .flag_clr_i(clr),
    .conv_busy_o(busy), .conv_sel_o(sel), .conv_ptr_o(ptr), .abort_o(abort),
    .q1_state_o(s1), .q2_state_o(s2), .flags_o(flags), .status_o(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic fire_q1();
    q1_sw = 1; step(); q1_sw = 0;
  endtask

  task automatic fire_done();
    done = 1; step(); done = 0;
  endtask

  task automatic clear_all();
    clr = 6'h3f; step(); clr = '0;
    chk("R11 clear all", flags, 0);
  endtask

  task automatic t_reset();
    chk("R1 q1 state", s1, 0);
    chk("R1 q2 state", s2, 0);
    chk("R1 flags", flags, 0);
    chk("R1 status", status, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ptr", ptr, 0);
  endtask

  task automatic t_q1_basic();
    q1_eoq = 8'b0000_0100;
    q1_ext = 1; step(); q1_ext = 0;
    chk("R2 q1 active", s1, 1);
    chk("R2 busy", busy, 1);
    chk("R2 sel q1", sel, 0);
    chk("R2 ptr0", ptr, 0);
    chk("R12 status q1 active", status, 4'b1000);
    fire_done(); chk("R2 ptr1", ptr, 1);
    fire_done(); chk("R2 ptr2", ptr, 2);
    fire_done();
    chk("R3 q1 idle at eoq", s1, 0);
    chk("R3 q1 complete flag", flags, 6'b000001);
    chk("R12 status idle", status, 0);
    clear_all();
  endtask

  task automatic t_pause();
    q1_pause = 8'b0000_0001; q1_eoq = 8'b0000_0100;
    fire_q1();
    fire_done();
    chk("R4 q1 paused", s1, 2);
    chk("R4 pause flag", flags, 6'b000010);
    chk("R12 status q1 paused", status, 4'b0100);
    chk("R4 not busy", busy, 0);
    fire_q1();
    chk("R4 resume active", s1, 1);
    chk("R4 resume ptr", ptr, 1);
    fire_done(); fire_done();
    chk("R3 idle after pause run", s1, 0);
    chk("R3 flags after pause run", flags, 6'b000011);
    q1_pause = '0;
    clear_all();
  endtask

  task automatic t_overrun_w1c();
    q1_eoq = 8'b0000_0001;
    fire_q1();
    fire_q1();
    chk("R6 q1 overrun flag", flags, 6'b000100);
    chk("R6 still active", s1, 1);
    chk("R6 ptr held", ptr, 0);
    q1_sw = 1; clr = 6'b000100; step(); q1_sw = 0; clr = '0;
    chk("R11 set beats clear", flags, 6'b000100);
    clr = 6'b000100; step(); clr = '0;
    chk("R11 clear one bit", flags, 0);
    fire_done();
    chk("R3 q1 done flag", flags, 6'b000001);
    clear_all();
  endtask

  task automatic t_preempt();
    q1_eoq = 8'b0000_0001; q2_eoq = 8'b0000_1000;
    q2_ext = 1; step(); q2_ext = 0;
    chk("R7 q2 ext start", s2, 1);
    chk("R2 sel q2", sel, 1);
    chk("R12 status q2 active", status, 4'b0010);
    fire_done(); chk("R2 q2 ptr1", ptr, 1);
    q1_sw = 1; done = 1; #1;
    chk("R8 abort pulse", abort, 1);
    step(); q1_sw = 0; done = 0;
    chk("R8 q2 suspended", s2, 3);
    chk("R8 q1 active", s1, 1);
    chk("R12 status suspended", status, 4'b1010);
    chk("R8 q1 owns ptr0", ptr, 0);
    chk("R8 discarded done", flags, 0);
    fire_done();
    chk("R9 q1 idle", s1, 0);
    chk("R9 q2 resumed", s2, 1);
    chk("R9 same word", ptr, 1);
    chk("R9 sel q2", sel, 1);
    fire_done(); fire_done();
    chk("R9 q2 ptr3", ptr, 3);
    fire_done();
    chk("R3 q2 idle", s2, 0);
    chk("R3 both complete", flags, 6'b001001);
    clear_all();
  endtask

  task automatic t_pending();
    q1_eoq = 8'b0000_0010; q2_eoq = 8'b0000_0001;
    q1_ext = 1; step(); q1_ext = 0;
    q2_tmr = 1; step(); q2_tmr = 0;
    chk("R10 q2 pending", s2, 4);
    chk("R12 status pending", status, 4'b1011);
    q2_sw = 1; step(); q2_sw = 0;
    chk("R6 q2 overrun when pending", flags, 6'b100000);
    fire_done(); fire_done();
    chk("R10 q1 stopped", s1, 0);
    chk("R10 transient code", status, 4'b0011);
    chk("R10 not yet busy", busy, 0);
    step();
    chk("R10 q2 active after one cycle", s2, 1);
    chk("R10 status after", status, 4'b0010);
    chk("R10 q2 ptr0", ptr, 0);
    fire_done();
    chk("R7 timer run complete", flags, 6'b101001);
    clear_all();
  endtask

  task automatic t_cont();
    q2_eoq = 8'b0000_0010; q2_cont = 1;
    q2_sw = 1; step(); q2_sw = 0;
    fire_done(); fire_done();
    chk("R5 still active", s2, 1);
    chk("R5 restart ptr", ptr, 0);
    chk("R5 complete flag", flags, 6'b001000);
    q2_cont = 0;
    fire_done(); fire_done();
    chk("R3 q2 idle after loop", s2, 0);
    clear_all();
  endtask

  task automatic t_implicit_end();
    q1_eoq = '0;
    fire_q1();
    for (int i = 0; i < DEPTH - 1; i++) begin
      fire_done();
      chk("R2 walk ptr", ptr, i + 1);
    end
    chk("R3 active before last", s1, 1);
    fire_done();
    chk("R3 last slot ends", s1, 0);
    chk("R3 last slot flag", flags, 6'b000001);
    clear_all();
  endtask

  task automatic t_q2_under_pause();
    q1_pause = 8'b0000_0001; q1_eoq = 8'b0000_0010; q2_eoq = 8'b0000_0001;
    fire_q1(); fire_done();
    chk("R4 q1 paused", status, 4'b0100);
    q2_ext = 1; step(); q2_ext = 0;
    chk("R7 q2 starts while q1 paused", s2, 1);
    chk("R12 status paused/active", status, 4'b0110);
    fire_done();
    chk("R12 back to paused/idle", status, 4'b0100);
    fire_q1();
    chk("R4 q1 resume ptr1", ptr, 1);
    fire_done();
    chk("R3 flags all", flags, 6'b001011);
    q1_pause = '0;
    clear_all();
  endtask

  task automatic t_simultaneous();
    q1_eoq = 8'b0000_0001; q2_eoq = 8'b0000_0001;
    q1_sw = 1; q2_sw = 1; step(); q1_sw = 0; q2_sw = 0;
    chk("R10 q1 wins tie", s1, 1);
    chk("R10 q2 pending on tie", s2, 4);
    fire_done();
    chk("R10 transient after tie", status, 4'b0011);
    step();
    chk("R10 q2 runs", status, 4'b0010);
    fire_done();
    chk("R12 idle", status, 0);
    clear_all();
  endtask

  task automatic t_idle_done();
    q1_eoq = 8'b0000_0001;
    fire_done();
    chk("R13 flags untouched", flags, 0);
    chk("R13 status idle", status, 0);
    chk("R13 not busy", busy, 0);
    fire_q1();
    chk("R13 q1 ptr unchanged", ptr, 0);
    fire_done();
    chk("R13 q1 completes", s1, 0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_q1_basic();
    t_pause();
    t_overrun_w1c();
    t_preempt();
    t_pending();
    t_cont();
    t_implicit_end();
    t_q2_under_pause();
    t_simultaneous();
    t_idle_done();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule